// File: doc/BRIEF.md
# Multi-subarray DRAM bank model

This block is a synthesizable behavioural model of a single DRAM bank whose rows are split across several subarrays. Each subarray has its own row-address latch and its own local row buffer, so several subarrays can hold an opened row at the same moment instead of the whole bank being limited to one open row. A small register memory stands in for the cell array, and rows move between the array and a local row buffer on open and close.

All subarrays share one global data path. A per-subarray ownership flag decides which local row buffer may drive it, and at most one flag is set at any time. Commands arrive one per cycle on a three-bit opcode, with a subarray index and an address field that carries a row (for opening) or a column (for reads and writes). Reads and writes always act on the subarray that currently owns the shared path; a select command moves ownership without touching any row. An illegal command raises a one-cycle error pulse and changes nothing.

Top module: `msb_bank`

## Requirements
- R1: Reset is synchronous and active high; after it no subarray is open, none owns the shared path, every array word reads zero, and `rd_valid` and `cmd_err` are low.
- R2: Opcode 1 (open) on a closed subarray latches the row given in the low row bits of `addr`, copies that stored row into the subarray's local buffer, and makes that subarray the sole owner of the shared path; other open subarrays stay open.
- R3: Opcode 5 (select) makes the addressed subarray the sole owner, whether it is open or closed, and no more than one subarray is ever an owner.
- R4: Opcode 3 (read) with an open owner returns, one cycle later, the owner's buffer word at the column given in the low column bits of `addr`, with `rd_valid` high for exactly that cycle; the `sub_idx` field has no effect on it.
- R5: Opcode 4 (write) with an open owner stores `wdata` into the owner's local buffer at the addressed column; a later read of that column returns it.
- R6: Opcode 2 (close) on an open subarray writes its local buffer back to its latched row and closes it; if that subarray owned the shared path, no subarray owns it afterwards; a close to a closed subarray leaves every row and the owner unchanged.
- R7: A read or write while no open subarray owns the path, or an open to an already open subarray, sets `cmd_err` for one cycle on the following cycle and leaves all buffers, latched rows, open states and ownership unchanged; `rd_valid` stays low.
- R8: Different subarrays keep different rows and buffer contents open together; moving ownership with select switches which buffer a read returns, without reloading any buffer.
- R9: Opcode 0 is a no-operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Opcode: 0 nop, 1 open, 2 close, 3 read, 4 write, 5 select |
| sub_idx | input | SUB_W (3) | Target subarray for open, close and select |
| addr | input | ADDR_W (3) | Row for open, column for read and write |
| wdata | input | DATA_W (16) | Write data placed on the shared path |
| rd_data | output | DATA_W (16) | Read data from the owning buffer |
| rd_valid | output | 1 | One-cycle strobe marking `rd_data` valid |
| cmd_err | output | 1 | One-cycle pulse for an illegal command |

## Verification
The hardest situation to reach from the ports is an owner that is closed while other subarrays remain open, or an owner that was selected while closed: nothing at the ports shows ownership directly. The stimulus opens two subarrays with different rows and contents, moves ownership back and forth with select, then closes the owner, selects a closed subarray and closes an unrelated closed one, and each time probes with a read whose result (data, or an error pulse) can only come out right if ownership and the open states are as the requirements say. Write-back is shown by closing, reopening the same row and reading the modified column, while a different row of the same subarray still reads zero.

// File: rtl/msb_pkg.sv
package msb_pkg;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_OPEN  = 3'd1,
        OP_CLOSE = 3'd2,
        OP_READ  = 3'd3,
        OP_WRITE = 3'd4,
        OP_SEL   = 3'd5
    } bank_op_e;

    // Per-subarray control strobes produced by the sequencer
    typedef struct packed {
        logic open;
        logic close;
        logic own;
        logic disown;
        logic wr;
    } sub_ctl_t;

    function automatic int safe_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/msb_cell_array.sv
module msb_cell_array #(
    parameter int NUM_SUB = 8,
    parameter int ROWS    = 4,
    parameter int LINE_W  = 128,
    parameter int SUB_W   = 3,
    parameter int ROW_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SUB_W-1:0]  rd_sub,
    input  logic [ROW_W-1:0]  rd_row,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [SUB_W-1:0]  wr_sub,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [LINE_W-1:0] wr_line
);
    localparam int DEPTH = NUM_SUB * ROWS;

    logic [LINE_W-1:0] store [DEPTH];

    function automatic int slot(input logic [SUB_W-1:0] s, input logic [ROW_W-1:0] r);
        return int'(s) * ROWS + int'(r);
    endfunction

    always_comb begin
        rd_line = store[slot(rd_sub, rd_row)];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                store[i] <= '0;
            end
        end else if (wr_en) begin
            store[slot(wr_sub, wr_row)] <= wr_line;
        end
    end

endmodule

// File: rtl/msb_subarray.sv
module msb_subarray
    import msb_pkg::*;
#(
    parameter int COLS   = 8,
    parameter int DATA_W = 16,
    parameter int ROW_W  = 2,
    parameter int COL_W  = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  sub_ctl_t               ctl,
    input  logic [ROW_W-1:0]       row_in,
    input  logic [COLS*DATA_W-1:0] fill_line,
    input  logic [COL_W-1:0]       col,
    input  logic [DATA_W-1:0]      wdata,
    output logic                   is_open,
    output logic                   is_owner,
    output logic [ROW_W-1:0]       row_q,
    output logic [COLS*DATA_W-1:0] line_q,
    output logic [DATA_W-1:0]      drive
);
    logic [COLS-1:0][DATA_W-1:0] line_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            is_open  <= 1'b0;
            is_owner <= 1'b0;
            row_q    <= '0;
            line_r   <= '0;
        end else begin
            if (ctl.open) begin
                is_open <= 1'b1;
                row_q   <= row_in;
                line_r  <= fill_line;
            end else if (ctl.close) begin
                is_open <= 1'b0;
            end
            if (ctl.wr) begin
                line_r[col] <= wdata;
            end
            if (ctl.own) begin
                is_owner <= 1'b1;
            end else if (ctl.disown) begin
                is_owner <= 1'b0;
            end
        end
    end

    assign line_q = line_r;
    // Only the owning buffer places a word on the shared bitlines
    assign drive  = is_owner ? line_r[col] : '0;

endmodule

// File: rtl/msb_sequencer.sv
module msb_sequencer
    import msb_pkg::*;
#(
    parameter int NUM_SUB = 8,
    parameter int SUB_W   = 3
) (
    input  bank_op_e           op,
    input  logic [SUB_W-1:0]   sub,
    input  logic [NUM_SUB-1:0] open_vec,
    input  logic [NUM_SUB-1:0] own_vec,
    output sub_ctl_t           ctl [NUM_SUB],
    output logic               rd_go,
    output logic               wb_go,
    output logic               fault
);
    logic owner_ready;

    assign owner_ready = |(open_vec & own_vec);

    always_comb begin
        rd_go = 1'b0;
        wb_go = 1'b0;
        fault = 1'b0;
        for (int i = 0; i < NUM_SUB; i++) begin
            ctl[i] = '0;
        end
        unique case (op)
            OP_OPEN: begin
                if (open_vec[sub]) begin
                    fault = 1'b1;
                end else begin
                    for (int i = 0; i < NUM_SUB; i++) begin
                        if (i == int'(sub)) begin
                            ctl[i].open = 1'b1;
                            ctl[i].own  = 1'b1;
                        end else begin
                            ctl[i].disown = 1'b1;
                        end
                    end
                end
            end
            OP_CLOSE: begin
                for (int i = 0; i < NUM_SUB; i++) begin
                    if (i == int'(sub)) begin
                        ctl[i].close  = open_vec[i];
                        ctl[i].disown = open_vec[i] && own_vec[i];
                    end
                end
                wb_go = open_vec[sub];
            end
            OP_READ: begin
                if (owner_ready) rd_go = 1'b1;
                else             fault = 1'b1;
            end
            OP_WRITE: begin
                if (owner_ready) begin
                    for (int i = 0; i < NUM_SUB; i++) begin
                        ctl[i].wr = own_vec[i];
                    end
                end else begin
                    fault = 1'b1;
                end
            end
            OP_SEL: begin
                for (int i = 0; i < NUM_SUB; i++) begin
                    if (i == int'(sub)) ctl[i].own    = 1'b1;
                    else                ctl[i].disown = 1'b1;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/msb_bank.sv
module msb_bank
    import msb_pkg::*;
#(
    parameter int NUM_SUB = 8,
    parameter int ROWS    = 4,
    parameter int COLS    = 8,
    parameter int DATA_W  = 16,
    localparam int SUB_W  = safe_width(NUM_SUB),
    localparam int ROW_W  = safe_width(ROWS),
    localparam int COL_W  = safe_width(COLS),
    localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cmd,
    input  logic [SUB_W-1:0]  sub_idx,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              cmd_err
);
    localparam int LINE_W = COLS * DATA_W;

    bank_op_e            op;
    logic [ROW_W-1:0]    row_sel;
    logic [COL_W-1:0]    col_sel;
    sub_ctl_t            ctl [NUM_SUB];
    logic                rd_go;
    logic                wb_go;
    logic                fault;
    logic [NUM_SUB-1:0]  open_vec;
    logic [NUM_SUB-1:0]  own_vec;
    logic [ROW_W-1:0]    row_a  [NUM_SUB];
    logic [LINE_W-1:0]   line_a [NUM_SUB];
    logic [DATA_W-1:0]   drive_a[NUM_SUB];
    logic [LINE_W-1:0]   fill_line;
    logic [DATA_W-1:0]   global_bus;

    assign op      = bank_op_e'(cmd);
    assign row_sel = addr[ROW_W-1:0];
    assign col_sel = addr[COL_W-1:0];

    msb_sequencer #(
        .NUM_SUB(NUM_SUB),
        .SUB_W  (SUB_W)
    ) seq_i (
        .op      (op),
        .sub     (sub_idx),
        .open_vec(open_vec),
        .own_vec (own_vec),
        .ctl     (ctl),
        .rd_go   (rd_go),
        .wb_go   (wb_go),
        .fault   (fault)
    );

    msb_cell_array #(
        .NUM_SUB(NUM_SUB),
        .ROWS   (ROWS),
        .LINE_W (LINE_W),
        .SUB_W  (SUB_W),
        .ROW_W  (ROW_W)
    ) cells_i (
        .clk    (clk),
        .rst    (rst),
        .rd_sub (sub_idx),
        .rd_row (row_sel),
        .rd_line(fill_line),
        .wr_en  (wb_go),
        .wr_sub (sub_idx),
        .wr_row (row_a[sub_idx]),
        .wr_line(line_a[sub_idx])
    );

    for (genvar g = 0; g < NUM_SUB; g++) begin : g_sub
        msb_subarray #(
            .COLS  (COLS),
            .DATA_W(DATA_W),
            .ROW_W (ROW_W),
            .COL_W (COL_W)
        ) sa_i (
            .clk      (clk),
            .rst      (rst),
            .ctl      (ctl[g]),
            .row_in   (row_sel),
            .fill_line(fill_line),
            .col      (col_sel),
            .wdata    (wdata),
            .is_open  (open_vec[g]),
            .is_owner (own_vec[g]),
            .row_q    (row_a[g]),
            .line_q   (line_a[g]),
            .drive    (drive_a[g])
        );
    end

    // Shared global bitlines: wired-OR of the gated subarray drivers
    always_comb begin
        global_bus = '0;
        for (int i = 0; i < NUM_SUB; i++) begin
            global_bus = global_bus | drive_a[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
            cmd_err  <= 1'b0;
        end else begin
            rd_valid <= rd_go;
            cmd_err  <= fault;
            if (rd_go) begin
                rd_data <= global_bus;
            end
        end
    end

endmodule

// File: rtl/msb_bank_checker.sv
module msb_bank_checker
    import msb_pkg::*;
#(
    parameter int NUM_SUB = 8,
    parameter int SUB_W   = 3
) (
    input logic               clk,
    input logic               rst,
    input logic [2:0]         cmd,
    input logic [SUB_W-1:0]   sub_idx,
    input logic [NUM_SUB-1:0] open_vec,
    input logic [NUM_SUB-1:0] own_vec,
    input logic               fault,
    input logic               rd_valid,
    input logic               cmd_err
);
    localparam logic [NUM_SUB-1:0] ONE = {{(NUM_SUB-1){1'b0}}, 1'b1};

    p_single_owner_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(own_vec));

    p_sel_owner_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd == OP_SEL) |=> (own_vec == (ONE << $past(sub_idx))));

    p_open_owner_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd == OP_OPEN && !open_vec[sub_idx])
        |=> (open_vec[$past(sub_idx)] && own_vec == (ONE << $past(sub_idx))));

    p_read_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd == OP_READ && |(open_vec & own_vec)) |=> (rd_valid && !cmd_err));

    p_close_state_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd == OP_CLOSE) |=> (!open_vec[$past(sub_idx)]));

    p_fault_freeze_r7: assert property (@(posedge clk) disable iff (rst)
        fault |=> (cmd_err && !rd_valid && $stable(open_vec) && $stable(own_vec)));

endmodule

bind msb_bank msb_bank_checker #(
    .NUM_SUB(NUM_SUB),
    .SUB_W  (SUB_W)
) chk_i (
    .clk     (clk),
    .rst     (rst),
    .cmd     (cmd),
    .sub_idx (sub_idx),
    .open_vec(open_vec),
    .own_vec (own_vec),
    .fault   (fault),
    .rd_valid(rd_valid),
    .cmd_err (cmd_err)
);

// File: tb/msb_bank_tb.sv
module msb_bank_tb_top;

    localparam int DW = 16;

    typedef struct {
        bit          rv;
        logic [DW-1:0] data;
        bit          er;
        string       tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    cmd = 3'd0;
    logic [2:0]    sub_idx = '0;
    logic [2:0]    addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic          cmd_err;

    int total = 0;
    int bad   = 0;
    exp_t sb [$];

    always #4 clk = ~clk;

    msb_bank dut_i (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .sub_idx (sub_idx),
        .addr    (addr),
        .wdata   (wdata),
        .rd_data (rd_data),
        .rd_valid(rd_valid),
        .cmd_err (cmd_err)
    );

    // Monitor: one expected item per issued command, compared after the edge
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            total++;
            if (rd_valid !== e.rv || cmd_err !== e.er || (e.rv && rd_data !== e.data)) begin
                bad++;
                $display("FAIL %s: got valid=%0b err=%0b data=%h, expected valid=%0b err=%0b data=%h",
                         e.tag, rd_valid, cmd_err, rd_data, e.rv, e.er, e.data);
            end
        end
    end

    task automatic issue(input logic [2:0] c, input int s, input int a, input logic [DW-1:0] d,
                         input bit rv, input logic [DW-1:0] ed, input bit er, input string tag);
        exp_t e;
        @(negedge clk);
        cmd = c; sub_idx = 3'(s); addr = 3'(a); wdata = d;
        e.rv = rv; e.data = ed; e.er = er; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic op_open(input int s, input int r, input bit ok, input string tag);
        issue(3'd1, s, r, '0, 1'b0, '0, !ok, tag);
    endtask
    task automatic op_close(input int s, input string tag);
        issue(3'd2, s, 0, '0, 1'b0, '0, 1'b0, tag);
    endtask
    task automatic op_sel(input int s, input string tag);
        issue(3'd5, s, 0, '0, 1'b0, '0, 1'b0, tag);
    endtask
    task automatic op_rd(input int c, input logic [DW-1:0] ed, input string tag);
        issue(3'd3, 0, c, '0, 1'b1, ed, 1'b0, tag);
    endtask
    task automatic op_rd_sub(input int s, input int c, input logic [DW-1:0] ed, input string tag);
        issue(3'd3, s, c, '0, 1'b1, ed, 1'b0, tag);
    endtask
    task automatic op_rd_bad(input int c, input string tag);
        issue(3'd3, 0, c, '0, 1'b0, '0, 1'b1, tag);
    endtask
    task automatic op_wr(input int c, input logic [DW-1:0] d, input bit ok, input string tag);
        issue(3'd4, 0, c, d, 1'b0, '0, !ok, tag);
    endtask
    task automatic op_nop(input string tag);
        issue(3'd0, 0, 0, 16'hFFFF, 1'b0, '0, 1'b0, tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got no end of run, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stimulus
        repeat (3) @(negedge clk);
        // R1: outputs idle while in reset
        total++;
        if (rd_valid !== 1'b0 || cmd_err !== 1'b0) begin
            bad++;
            $display("FAIL R1: got valid=%0b err=%0b, expected 0 0", rd_valid, cmd_err);
        end
        rst = 1'b0;

        // R7 / R1: nothing open and nobody owns the path
        op_rd_bad(0, "R7 read with no owner after reset");
        op_wr(1, 16'h1111, 1'b0, "R7 write with no owner");
        op_nop("R9 nop");

        // R2 / R1: open loads a zero row
        op_open(0, 1, 1'b1, "R2 open sub0 row1");
        op_rd(3, 16'h0000, "R1 array reads zero");
        op_wr(3, 16'hA5A5, 1'b1, "R5 write sub0 col3");
        op_rd(3, 16'hA5A5, "R5 read back col3");
        op_rd_sub(5, 3, 16'hA5A5, "R4 sub_idx field ignored on read");
        op_rd(2, 16'h0000, "R5 neighbour column untouched");

        // R2 / R8: second subarray open alongside
        op_open(2, 0, 1'b1, "R2 open sub2 row0");
        op_wr(0, 16'h1234, 1'b1, "R5 write sub2 col0");
        op_rd(0, 16'h1234, "R8 read sub2 col0");
        op_rd(3, 16'h0000, "R8 sub2 buffer separate from sub0");
        op_sel(0, "R3 select sub0");
        op_rd(3, 16'hA5A5, "R8 sub0 still holds its row");
        op_sel(2, "R3 select sub2");
        op_rd(0, 16'h1234, "R8 sub2 buffer kept across select");

        // R7: open of an open subarray is refused without change
        op_open(0, 2, 1'b0, "R7 open of open sub0");
        op_rd(0, 16'h1234, "R7 owner unchanged after refused open");
        op_sel(0, "R3 select sub0 again");
        op_rd(3, 16'hA5A5, "R7 sub0 buffer not reloaded");

        // R3 / R7: owner that is closed
        op_sel(5, "R3 select closed sub5");
        op_rd_bad(0, "R7 read with closed owner");
        op_wr(0, 16'hBEEF, 1'b0, "R7 write with closed owner");

        // R6: close of a closed subarray has no effect
        op_sel(2, "R3 select sub2");
        op_close(5, "R6 close closed sub5");
        op_rd(0, 16'h1234, "R6 owner kept after close of closed sub");

        // R6: closing the owner drops ownership
        op_close(2, "R6 close owning sub2");
        op_rd_bad(0, "R6 no owner after closing owner");
        op_sel(0, "R3 select sub0");
        op_rd(3, 16'hA5A5, "R6 sub0 untouched by close of sub2");

        // R6: write-back on close
        op_close(0, "R6 close sub0");
        op_open(0, 1, 1'b1, "R6 reopen sub0 row1");
        op_rd(3, 16'hA5A5, "R6 written word stored back");
        op_open(2, 0, 1'b1, "R6 reopen sub2 row0");
        op_rd(0, 16'h1234, "R6 sub2 word stored back");
        op_close(0, "R6 close sub0");
        op_open(0, 2, 1'b1, "R6 open sub0 row2");
        op_rd(3, 16'h0000, "R6 other row unaffected");
        op_close(0, "R6 close sub0");
        op_close(2, "R6 close sub2");

        // R8: all subarrays open together on row 3
        for (int i = 0; i < 8; i++) begin
            op_open(i, 3, 1'b1, "R8 open all");
            op_wr(i, 16'h0100 + 16'(i), 1'b1, "R8 write per sub");
        end
        for (int i = 0; i < 8; i++) begin
            op_sel(i, "R8 select each");
            op_rd(i, 16'h0100 + 16'(i), "R8 read per sub");
        end
        for (int i = 0; i < 8; i++) begin
            op_close(i, "R6 close all");
        end
        for (int i = 0; i < 8; i++) begin
            op_open(i, 3, 1'b1, "R6 reopen all");
            op_rd(i, 16'h0100 + 16'(i), "R6 write-back per sub");
        end

        op_nop("R9 drain");
        op_nop("R9 drain");
        repeat (4) @(posedge clk);
        #3;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule